// File: doc/BRIEF.md
# Non-Blocking Capitulating Load Unit

This unit sits in front of a small direct-mapped data cache. It serves a load that never waits. If the addressed word is present, the unit returns the word one cycle later with a non-zero status code. If the word is absent, the unit returns a zero status in that same cycle slot. It also starts a line fill in the background, the same way a prefetch would. Software tests the status and branches. It either uses the data or goes on with other work and retries later.

The unit holds the tag, valid and data arrays and a single outstanding-miss tracker. It talks to the memory side through a request/response handshake. The request carries a line address and stays asserted until the memory accepts it. The memory later returns the whole 16-byte line in a single beat, and the unit writes that line into the cache. Plain prefetch requests take the same lookup path but produce no response. A load that arrives in the same cycle as the fill of its own line is served from the returning data.

Top module: `nbload_unit`

## Requirements
- R1: Every load (reqValid high, reqPrefetch low) gets rspValid high in the cycle after the request. This holds for hits and misses alike, and there is no back-pressure signal towards the requester.
- R2: On a hit the response carries the word selected by address bits [3:2] of the cached line, and rspStatus equals HIT_CODE (default 4'h9).
- R3: On a miss the response carries rspStatus = 0 and rspData = 0.
- R4: A miss or prefetch-miss finding the tracker idle raises memReqValid in the next cycle, with memReqLine = reqAddr[15:4]. memReqValid and memReqLine then stay unchanged until a cycle in which memReqReady is high.
- R5: A memory response is written into the line held by the tracker. Word w of the line is memRspData[32w+31:32w]. Every word of that line then hits.
- R6: A miss to the line that the tracker already holds issues no further memory request.
- R7: A miss to a different line while the tracker is busy returns zero status and is not remembered. After the pending fill, that line still misses and must be requested anew.
- R8: A prefetch (reqPrefetch high) produces no response. On a miss it starts a fill exactly as a load miss does. A hitting prefetch has no effect.
- R9: The cache is direct-mapped with 32 lines: index = reqAddr[8:4], tag = reqAddr[15:9]. A fill replaces whatever line held the same index.
- R10: A load to the tracked line in the cycle that memRspValid is high is answered as a hit with the returning data.
- R11: After reset all lines are invalid, and rspValid and memReqValid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqPrefetch | input | 1 | 1 = prefetch only, 0 = capitulating load |
| reqAddr | input | 16 | Byte address of the request |
| rspValid | output | 1 | Load response present |
| rspData | output | 32 | Loaded word, zero on a miss |
| rspStatus | output | 4 | HIT_CODE on a hit, zero on a miss |
| memReqValid | output | 1 | Line fill request to memory |
| memReqReady | input | 1 | Memory accepts the fill request |
| memReqLine | output | 12 | Line address being fetched |
| memRspValid | input | 1 | Fill data present |
| memRspData | input | 128 | Whole line of fill data |

## Verification
A load response is due one clock edge after its request: the request is driven after a falling edge and the response is read at the next falling edge. A miss shows on memReqValid after the same single edge. The fill is written at the edge that samples memRspValid, so the bench reads only after that edge. For R6, R7 and R8 it checks the number of accepted memory requests several cycles later. For R10 it drives the load in the same cycle as the fill beat and reads the answer one edge later.

// File: rtl/nbl_pkg.sv
package nbl_pkg;

  typedef enum logic [1:0] {
    TRK_IDLE = 2'd0,
    TRK_ASK  = 2'd1,
    TRK_WAIT = 2'd2
  } trkState_t;

  typedef struct packed {
    logic fillWe;   // write the returning line into the arrays
    logic bypass;   // answer the current load from the returning line
  } ctrlStrobe_t;

endpackage

// File: rtl/nbl_datapath.sv
module nbl_datapath
  import nbl_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINES      = 32,
  parameter int LINE_BYTES = 16,
  parameter int DATA_W     = 32,
  parameter int STATUS_W   = 4,
  parameter logic [STATUS_W-1:0] HIT_CODE = 4'h9,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int FILL_W = LINE_BYTES * 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqPrefetch,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [FILL_W-1:0]   fillData,
  input  ctrlStrobe_t         strobe,
  input  logic [LINE_W-1:0]   trkLine,
  output logic                arrHit,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspData,
  output logic [STATUS_W-1:0] rspStatus
);

  localparam int WORDS  = FILL_W / DATA_W;
  localparam int WSEL_W = $clog2(WORDS);
  localparam int BSEL_W = $clog2(DATA_W / 8);

  logic [IDX_W-1:0]  reqIdx;
  logic [TAG_W-1:0]  reqTag;
  logic [WSEL_W-1:0] reqWord;
  logic [IDX_W-1:0]  fillIdx;
  logic [TAG_W-1:0]  fillTag;

  assign reqIdx  = reqAddr[OFF_W +: IDX_W];
  assign reqTag  = reqAddr[ADDR_W-1 -: TAG_W];
  assign reqWord = reqAddr[BSEL_W +: WSEL_W];
  assign fillIdx = trkLine[IDX_W-1:0];
  assign fillTag = trkLine[LINE_W-1 -: TAG_W];

  logic [LINES-1:0]  validQ;
  logic [TAG_W-1:0]  tagQ  [LINES];
  logic [FILL_W-1:0] dataQ [LINES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
    end else if (strobe.fillWe) begin
      validQ[fillIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fillWe) begin
      tagQ[fillIdx]  <= fillTag;
      dataQ[fillIdx] <= fillData;
    end
  end

  logic [FILL_W-1:0] arrLine;
  logic [DATA_W-1:0] arrWords  [WORDS];
  logic [DATA_W-1:0] fillWords [WORDS];

  assign arrLine = dataQ[reqIdx];

  for (genvar w = 0; w < WORDS; w++) begin : gWord
    assign arrWords[w]  = arrLine[w*DATA_W +: DATA_W];
    assign fillWords[w] = fillData[w*DATA_W +: DATA_W];
  end

  assign arrHit = validQ[reqIdx] && (tagQ[reqIdx] == reqTag);

  logic              hitNow;
  logic              loadNow;
  logic [DATA_W-1:0] selWord;

  assign hitNow  = arrHit || strobe.bypass;
  assign loadNow = reqValid && !reqPrefetch;
  assign selWord = strobe.bypass ? fillWords[reqWord] : arrWords[reqWord];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspData   <= '0;
      rspStatus <= '0;
    end else begin
      rspValid  <= loadNow;
      rspData   <= (loadNow && hitNow) ? selWord : '0;
      rspStatus <= (loadNow && hitNow) ? HIT_CODE : '0;
    end
  end

  // R1
  rsp_next_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqPrefetch) |=> rspValid);

  // R8
  no_rsp_for_prefetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqPrefetch) |=> !rspValid);

  // R3
  zero_data_on_fail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspStatus == '0) |-> (rspData == '0));

  // R2
  status_only_with_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspStatus != '0) |-> (rspValid && rspStatus == HIT_CODE));

endmodule

// File: rtl/nbl_control.sv
module nbl_control
  import nbl_pkg::*;
#(
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [LINE_W-1:0] reqLine,
  input  logic              arrHit,
  input  logic              memReqReady,
  input  logic              memRspValid,
  output logic              memReqValid,
  output logic [LINE_W-1:0] memReqLine,
  output ctrlStrobe_t       strobe,
  output logic [LINE_W-1:0] trkLine
);

  trkState_t stateQ;
  trkState_t stateD;
  logic      fillBeat;
  logic      missNow;

  assign fillBeat      = (stateQ == TRK_WAIT) && memRspValid;
  assign strobe.fillWe = fillBeat;
  assign strobe.bypass = fillBeat && reqValid && (trkLine == reqLine);
  assign missNow       = reqValid && !arrHit && !strobe.bypass;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      TRK_IDLE: if (missNow)     stateD = TRK_ASK;
      TRK_ASK:  if (memReqReady) stateD = TRK_WAIT;
      TRK_WAIT: if (memRspValid) stateD = TRK_IDLE;
      default:                   stateD = TRK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= TRK_IDLE;
      trkLine <= '0;
    end else begin
      stateQ <= stateD;
      if (stateQ == TRK_IDLE && missNow) begin
        trkLine <= reqLine;
      end
    end
  end

  assign memReqValid = (stateQ == TRK_ASK);
  assign memReqLine  = trkLine;

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqLine)));

  // R4
  req_from_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReqValid) |-> $past(reqValid));

  // R6
  tracker_line_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != TRK_IDLE) |=> $stable(trkLine));

  // R5
  fill_frees_tracker_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fillWe |=> (!memReqValid && !strobe.fillWe));

endmodule

// File: rtl/nbload_unit.sv
module nbload_unit
  import nbl_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINES      = 32,
  parameter int LINE_BYTES = 16,
  parameter int DATA_W     = 32,
  parameter int STATUS_W   = 4,
  parameter logic [STATUS_W-1:0] HIT_CODE = 4'h9,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int FILL_W = LINE_BYTES * 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqPrefetch,
  input  logic [ADDR_W-1:0]   reqAddr,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspData,
  output logic [STATUS_W-1:0] rspStatus,
  output logic                memReqValid,
  input  logic                memReqReady,
  output logic [LINE_W-1:0]   memReqLine,
  input  logic                memRspValid,
  input  logic [FILL_W-1:0]   memRspData
);

  ctrlStrobe_t       strobe;
  logic [LINE_W-1:0] trkLine;
  logic              arrHit;

  nbl_control #(
    .LINE_W(LINE_W)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqLine    (reqAddr[ADDR_W-1:OFF_W]),
    .arrHit     (arrHit),
    .memReqReady(memReqReady),
    .memRspValid(memRspValid),
    .memReqValid(memReqValid),
    .memReqLine (memReqLine),
    .strobe     (strobe),
    .trkLine    (trkLine)
  );

  nbl_datapath #(
    .ADDR_W    (ADDR_W),
    .LINES     (LINES),
    .LINE_BYTES(LINE_BYTES),
    .DATA_W    (DATA_W),
    .STATUS_W  (STATUS_W),
    .HIT_CODE  (HIT_CODE)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqPrefetch(reqPrefetch),
    .reqAddr    (reqAddr),
    .fillData   (memRspData),
    .strobe     (strobe),
    .trkLine    (trkLine),
    .arrHit     (arrHit),
    .rspValid   (rspValid),
    .rspData    (rspData),
    .rspStatus  (rspStatus)
  );

endmodule

// File: tb/sim_nbload_unit.sv
module sim_nbload_unit;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqPrefetch = 1'b0;
  logic [15:0]  reqAddr = '0;
  logic         rspValid;
  logic [31:0]  rspData;
  logic [3:0]   rspStatus;
  logic         memReqValid;
  logic         memReqReady = 1'b1;
  logic [11:0]  memReqLine;
  logic         memRspValid = 1'b0;
  logic [127:0] memRspData = '0;

  int errors = 0;
  int checks = 0;
  int reqCount = 0;
  int fireReq = 0;
  logic [11:0] lastLine = '0;
  logic readyOn = 1'b1;
  logic autoResp = 1'b1;
  logic done = 1'b0;

  localparam logic [3:0] HIT = 4'h9;

  always #4 clk = ~clk;

  nbload_unit u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPrefetch(reqPrefetch),
    .reqAddr(reqAddr), .rspValid(rspValid), .rspData(rspData), .rspStatus(rspStatus),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqLine(memReqLine),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  function automatic logic [31:0] wordOf(input logic [11:0] line, input int w);
    return 32'hC000_0000 | (32'(line) << 8) | (32'(w) << 4) | 32'h3;
  endfunction

  function automatic logic [127:0] lineOf(input logic [11:0] line);
    logic [127:0] v;
    for (int w = 0; w < 4; w++) v[w*32 +: 32] = wordOf(line, w);
    return v;
  endfunction

  // memory model: driven at falling edges
  initial begin
    int cd = 0;
    int fireDone = 0;
    logic [11:0] held = '0;
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin memRspValid = 1'b1; memRspData = lineOf(held); end
      end else if (fireReq != fireDone) begin
        fireDone = fireReq;
        memRspValid = 1'b1;
        memRspData = lineOf(held);
      end
      memReqReady = readyOn;
      if (memReqValid && readyOn && rstN) begin
        held = memReqLine;
        lastLine = memReqLine;
        reqCount++;
        if (autoResp) cd = 2;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReq(input logic [15:0] a, input logic pf,
                       output logic v, output logic [31:0] d, output logic [3:0] s);
    @(negedge clk);
    reqValid = 1'b1; reqPrefetch = pf; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0; reqPrefetch = 1'b0;
    v = rspValid; d = rspData; s = rspStatus;
  endtask

  task automatic expectMiss(input string req, input logic [15:0] a);
    logic v; logic [31:0] d; logic [3:0] s;
    doReq(a, 1'b0, v, d, s);
    check({req, " valid"}, 32'(v), 32'd1);
    check({req, " status"}, 32'(s), 32'd0);
    check({req, " data"}, d, 32'd0);
  endtask

  task automatic expectHit(input string req, input logic [15:0] a);
    logic v; logic [31:0] d; logic [3:0] s;
    doReq(a, 1'b0, v, d, s);
    check({req, " valid"}, 32'(v), 32'd1);
    check({req, " status"}, 32'(s), 32'(HIT));
    check({req, " data"}, d, wordOf(a[15:4], int'(a[3:2])));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] mk(input int tag, input int idx, input int w);
    return {7'(tag), 5'(idx), 2'(w), 2'b00};
  endfunction

  task automatic finishRun;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=expired expected=done");
      finishRun();
    end
  end

  initial begin
    int base;
    logic v; logic [31:0] d; logic [3:0] s;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 rspValid", 32'(rspValid), 32'd0);
    check("R11 memReqValid", 32'(memReqValid), 32'd0);

    // R1 R2 R3 R4 R5 R9: sweep every index with tag 1
    for (int i = 0; i < 32; i++) begin
      base = reqCount;
      expectMiss("R3 sweep miss", mk(1, i, 1));
      idle(6);
      check("R4 sweep request count", 32'(reqCount), 32'(base + 1));
      check("R4 sweep line", 32'(lastLine), 32'(mk(1, i, 0) >> 4));
      for (int w = 0; w < 4; w++) expectHit("R5 R2 sweep hit", mk(1, i, w));
    end

    // R9 eviction by same index, other tag
    expectMiss("R9 other tag miss", mk(2, 0, 0));
    idle(6);
    expectHit("R9 other tag hit", mk(2, 0, 3));
    expectMiss("R9 evicted line", mk(1, 0, 0));
    idle(6);
    expectHit("R9 refetched", mk(1, 0, 2));

    // R6 merge: second miss to same line issues no request
    autoResp = 1'b0;
    base = reqCount;
    expectMiss("R6 first miss", mk(5, 3, 0));
    idle(2);
    expectMiss("R6 repeat miss", mk(5, 3, 1));
    idle(3);
    check("R6 request count", 32'(reqCount), 32'(base + 1));
    fireReq++;
    idle(3);
    expectHit("R6 after fill", mk(5, 3, 1));

    // R7 drop: other line while busy
    base = reqCount;
    expectMiss("R7 tracked miss", mk(6, 4, 0));
    idle(2);
    expectMiss("R7 busy miss", mk(7, 9, 2));
    idle(3);
    check("R7 request count", 32'(reqCount), 32'(base + 1));
    fireReq++;
    idle(3);
    expectHit("R7 tracked hit", mk(6, 4, 0));
    expectMiss("R7 dropped still misses", mk(7, 9, 2));
    idle(3);
    check("R7 new request", 32'(reqCount), 32'(base + 2));
    check("R7 new request line", 32'(lastLine), 32'(mk(7, 9, 0) >> 4));
    fireReq++;
    idle(3);
    expectHit("R7 refilled", mk(7, 9, 2));

    // R10 bypass in the fill cycle
    expectMiss("R10 miss", mk(9, 12, 0));
    idle(3);
    fireReq++;
    doReq(mk(9, 12, 2), 1'b0, v, d, s);
    check("R10 bypass status", 32'(s), 32'(HIT));
    check("R10 bypass data", d, wordOf(12'(mk(9, 12, 0) >> 4), 2));
    idle(2);
    expectHit("R10 stored", mk(9, 12, 1));
    autoResp = 1'b1;

    // R4 request held while not ready
    readyOn = 1'b0;
    base = reqCount;
    expectMiss("R4 stall miss", mk(11, 20, 0));
    idle(4);
    check("R4 held valid", 32'(memReqValid), 32'd1);
    check("R4 held line", 32'(memReqLine), 32'(mk(11, 20, 0) >> 4));
    check("R4 not accepted", 32'(reqCount), 32'(base));
    readyOn = 1'b1;
    idle(6);
    check("R4 accepted once", 32'(reqCount), 32'(base + 1));
    expectHit("R4 after stall", mk(11, 20, 3));

    // R8 prefetch: no response, starts fill; hitting prefetch does nothing
    base = reqCount;
    doReq(mk(13, 25, 0), 1'b1, v, d, s);
    check("R8 no response", 32'(v), 32'd0);
    idle(6);
    check("R8 prefetch request", 32'(reqCount), 32'(base + 1));
    expectHit("R8 prefetched hit", mk(13, 25, 1));
    doReq(mk(13, 25, 2), 1'b1, v, d, s);
    check("R8 hit prefetch no response", 32'(v), 32'd0);
    idle(4);
    check("R8 hit prefetch no request", 32'(reqCount), 32'(base + 1));

    idle(2);
    finishRun();
  end

endmodule